// File: doc/BRIEF.md
# Odd-Ratio Symmetric Clock Divider

This block takes an input clock and divides it by an odd ratio, 3 or 5, chosen at elaboration. The output clock has a 50% duty cycle: it stays high for exactly half of its period, that is N/2 input periods for a ratio of N. A counter that advances on one edge cannot give a half-period resolution, so the block uses two circular shift registers of length N. One rotates on the rising edge of the input clock. The other rotates on the falling edge. The output is the AND of their low bits, with no other gate on the path, so it cannot glitch.

An active-high reset acts at once, independent of either clock edge. It loads both rings with the seed pattern and forces the output low. After reset is released, the output settles into its steady waveform within one output period. The duty cycle of the output is exact only when the input clock is itself symmetric. An uneven input gives an output whose imbalance is reduced but not removed.

Top module: `odd_clk_div`

## Requirements
- R1: The parameter RATIO selects the ratio and is either 3 or 5; any other value stops elaboration. In steady state the output period is exactly RATIO input periods.
- R2: While `rst` is high, both rings hold the seed and `clk_out` is low. The seed has (RATIO+1)/2 ones in the upper bits and (RATIO-1)/2 zeros in the lower bits: 110 for 3, 11100 for 5. Raising `rst` pulls `clk_out` low at once, without waiting for a clock edge.
- R3: Each ring rotates toward bit 0, with bit 0 wrapping into the top bit. The first ring rotates on the rising edge of `clk_in` and the second on the falling edge. If reset is released while `clk_in` is high, the first output rise comes (RATIO-3)/2 input periods after the first rising edge that follows the release.
- R4: `clk_out` is the AND of the two rings' bit 0. Count half input periods from the first rising edge after a release made while `clk_in` is low, taking k as the index of each half period. The output is high exactly when k-(RATIO-2) is non-negative and, taken modulo 2*RATIO, is below RATIO.
- R5: With a symmetric input clock, every high phase and every low phase of `clk_out` lasts RATIO half input periods.
- R6: If reset is released while `clk_in` is low, the first rise of `clk_out` comes RATIO-2 half input periods after the next rising edge of `clk_in`. This is within one output period.
- R7: Outside reset, `clk_out` never shows a pulse, high or low, shorter than half an input period.
- R8: Any number of input clock edges while `rst` is high leaves `clk_out` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided; both of its edges are used |
| rst | input | 1 | Active-high reset, acts at once; loads the seed and holds the output low |
| clk_out | output | 1 | Divided clock, RATIO input periods long with a 50% duty cycle |

## Verification
Two functions can act in the same instant: the reset that forces the output low, and the ring rotation that drives the output edges. The bench provokes this by raising reset while the output has just gone high. It expects the output to be low one nanosecond later, and it requires the rings to stay frozen through the clock edges that follow during reset. Reset is then released in both phases of the input clock, so that either ring can be the first to move. The timing of the first output edge is judged against the expected count of half periods for each case, and every later high and low phase is timed against RATIO half periods.

// File: rtl/odd_div_pkg.sv
`timescale 1ns/1ps
package odd_div_pkg;

    // Which edge of the source clock advances a ring
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_e;

    // Seed: the upper (n+1)/2 bits are ones, the lower (n-1)/2 bits are zeros
    function automatic logic [31:0] seed_pattern(input int n);
        logic [31:0] pat;
        pat = '0;
        for (int i = 0; i < n; i++) begin
            pat[i] = (i >= n / 2);
        end
        return pat;
    endfunction

endpackage

// File: rtl/odd_div_ring.sv
`timescale 1ns/1ps
module odd_div_ring
    import odd_div_pkg::*;
#(
    parameter int    WIDTH = 3,
    parameter edge_e EDGE  = EDGE_RISE
) (
    input  logic clk,
    input  logic rst,
    output logic lsb
);

    localparam logic [31:0]      SEED_FULL = seed_pattern(WIDTH);
    localparam logic [WIDTH-1:0] SEED      = SEED_FULL[WIDTH-1:0];
    localparam int               ONES      = (WIDTH + 1) / 2;

    typedef struct packed {
        logic [WIDTH-1:0] ring;
    } ring_s;

    ring_s st_d;
    ring_s st_q;

    // Next state: rotate toward bit 0, bit 0 wraps into the top position
    always_comb begin
        st_d      = st_q;
        st_d.ring = {st_q.ring[0], st_q.ring[WIDTH-1:1]};
    end

    generate
        if (EDGE == EDGE_RISE) begin : g_rise
            always_ff @(posedge clk or posedge rst) begin
                if (rst) begin
                    st_q <= '{ring: SEED};
                end else begin
                    st_q <= st_d;
                end
            end

            AST_RING_WEIGHT: assert property (@(posedge clk) disable iff (rst)
                $countones(st_q.ring) == ONES); // R3
        end else begin : g_fall
            always_ff @(negedge clk or posedge rst) begin
                if (rst) begin
                    st_q <= '{ring: SEED};
                end else begin
                    st_q <= st_d;
                end
            end

            AST_RING_WEIGHT: assert property (@(negedge clk) disable iff (rst)
                $countones(st_q.ring) == ONES); // R3
        end
    endgenerate

    assign lsb = st_q.ring[0];

endmodule

// File: rtl/odd_div_merge.sv
`timescale 1ns/1ps
module odd_div_merge (
    input  logic rise_bit,
    input  logic fall_bit,
    output logic div_clk
);

    // Single gate on the output path: both terms come straight from flops
    assign div_clk = rise_bit & fall_bit;

endmodule

// File: rtl/odd_clk_div.sv
`timescale 1ns/1ps
module odd_clk_div
    import odd_div_pkg::*;
#(
    parameter int RATIO = 3
) (
    input  logic clk_in,
    input  logic rst,
    output logic clk_out
);

    localparam int HI_SAMPLES = (RATIO + 1) / 2;
    localparam int LO_SAMPLES = (RATIO - 1) / 2;
    localparam int CNT_W      = $clog2(RATIO + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    generate
        if ((RATIO != 3) && (RATIO != 5)) begin : g_bad_ratio
            $error("odd_clk_div: RATIO must be 3 or 5"); // R1
        end
    endgenerate

    logic rise_lsb;
    logic fall_lsb;

    odd_div_ring #(
        .WIDTH (RATIO),
        .EDGE  (EDGE_RISE)
    ) i_ring_rise (
        .clk (clk_in),
        .rst (rst),
        .lsb (rise_lsb)
    );

    odd_div_ring #(
        .WIDTH (RATIO),
        .EDGE  (EDGE_FALL)
    ) i_ring_fall (
        .clk (clk_in),
        .rst (rst),
        .lsb (fall_lsb)
    );

    odd_div_merge i_merge (
        .rise_bit (rise_lsb),
        .fall_bit (fall_lsb),
        .div_clk  (clk_out)
    );

    // Rising-edge view of the output, used only by the assertions below
    typedef struct packed {
        logic             lvl;
        logic             armed;
        logic [CNT_W-1:0] per_cnt;
        logic [CNT_W-1:0] hi_cnt;
    } mon_s;

    mon_s mon_d;
    mon_s mon_q;

    always_comb begin
        mon_d     = mon_q;
        mon_d.lvl = clk_out;
        if (clk_out && !mon_q.lvl) begin
            mon_d.armed   = 1'b1;
            mon_d.per_cnt = 1;
            mon_d.hi_cnt  = 1;
        end else begin
            if (mon_q.per_cnt != CNT_MAX) begin
                mon_d.per_cnt = mon_q.per_cnt + 1'b1;
            end
            if (!clk_out) begin
                mon_d.hi_cnt = '0;
            end else if (mon_q.hi_cnt != CNT_MAX) begin
                mon_d.hi_cnt = mon_q.hi_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_in or posedge rst) begin
        if (rst) begin
            mon_q <= '0;
        end else begin
            mon_q <= mon_d;
        end
    end

    AST_PERIOD_RUN: assert property (@(posedge clk_in) disable iff (rst)
        (mon_q.armed && clk_out && !mon_q.lvl) |-> (mon_q.per_cnt == RATIO)); // R1

    AST_HIGH_RUN: assert property (@(posedge clk_in) disable iff (rst)
        (mon_q.lvl && !clk_out) |->
        ((mon_q.hi_cnt == HI_SAMPLES) || (mon_q.hi_cnt == LO_SAMPLES))); // R5

    always @(negedge clk_in) begin
        if (rst) begin
            AST_OUT_LOW_IN_RST: assert (clk_out == 1'b0); // R2 R8
        end
    end

endmodule

// File: tb/test_odd_clk_div.sv
`timescale 1ns/1ps
module test_odd_clk_div;

    localparam int N    = 3;
    localparam int HALF = 10;   // 50 MHz input: 20 ns period

    typedef struct packed {
        int hold;
        int periods;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{hold: 3, periods: 4},
        '{hold: 1, periods: 6},
        '{hold: 6, periods: 2},
        '{hold: 2, periods: 3}
    };

    logic clk_in  = 1'b0;
    logic rst     = 1'b1;
    logic clk_out;

    int  checks  = 0;
    int  errors  = 0;
    bit  done    = 0;
    bit  ended   = 0;
    int  glitches = 0;
    bit  arm_first = 0;
    longint first_rise = 0;
    longint last_edge  = 0;
    bit  have_edge = 0;

    odd_clk_div #(.RATIO(N)) i_odd_clk_div (
        .clk_in  (clk_in),
        .rst     (rst),
        .clk_out (clk_out)
    );

    always #HALF clk_in = ~clk_in;

    // Edge monitor: first rise after release, and narrow pulse detection (R7)
    always @(clk_out) begin
        if (rst) begin
            have_edge = 0;
        end else begin
            if (have_edge && (($time - last_edge) < HALF)) glitches++;
            if (clk_out && arm_first) begin
                first_rise = $time;
                arm_first  = 0;
            end
            last_edge = $time;
            have_edge = 1;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic measure(input int count);
        longint t1, t2, t3;
        for (int m = 0; m < count; m++) begin
            @(posedge clk_out); t1 = $time;
            @(negedge clk_out); t2 = $time;
            @(posedge clk_out); t3 = $time;
            chk("R5 high time", t2 - t1, N * HALF);
            chk("R5 low time",  t3 - t2, N * HALF);
            chk("R1 period",    t3 - t1, 2 * N * HALF);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk_in);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        longint tp;
        #3;
        chk("R2 reset output low", clk_out, 0);

        for (int v = 0; v < 4; v++) begin
            // Async reset, raised right after an output rise (R2)
            rst = 1'b1;
            #1;
            chk("R2 async clear", clk_out, 0);
            // Clock keeps running during reset (R8)
            for (int c = 0; c < VECS[v].hold; c++) begin
                @(posedge clk_in); #5;
                chk("R8 low in reset", clk_out, 0);
                @(negedge clk_in); #5;
                chk("R8 low in reset", clk_out, 0);
            end
            // Release in the low phase of the input clock
            @(negedge clk_in); #2;
            rst = 1'b0;
            arm_first = 1;
            @(posedge clk_in);
            tp = $time;
            #5;
            for (int h = 0; h < 4 * N; h++) begin
                int e;
                int lvl;
                e   = h - (N - 2);
                lvl = (e >= 0 && (e % (2 * N)) < N) ? 1 : 0;
                chk("R4 half-period sample", clk_out, lvl);
                #HALF;
            end
            chk("R6 first rise delay", first_rise - tp, (N - 2) * HALF);
            chk("R6 within one period", (first_rise - tp) <= 2 * N * HALF, 1);
            measure(VECS[v].periods);
        end

        // Release while the input clock is high: the falling ring moves first (R3)
        rst = 1'b1;
        #1;
        chk("R2 async clear", clk_out, 0);
        @(posedge clk_in); #3;
        rst = 1'b0;
        arm_first = 1;
        @(negedge clk_in);
        @(posedge clk_in);
        tp = $time;
        repeat (2 * N) @(posedge clk_in);
        chk("R3 first rise, release in high phase", first_rise - tp, (N - 3) * HALF);
        measure(2);

        chk("R7 no narrow pulse", glitches, 0);

        done = 1;
        finish_run();
    end

endmodule